// File: doc/BRIEF.md
# Serial Three-Symbol Sequence Detector

This block watches a single-bit serial stream, one symbol per clock, and raises its output in the same cycle as the final symbol of the pattern zero, zero, one. The symbol called "a" is carried as 0 and "b" as 1, so the pattern is the stream `0 0 1`. The output is a Mealy output: it is a combinational function of the stored state and the present input. It is therefore valid within the cycle that presents the closing `1`, and it is not delayed by a register stage.

Runs of zeros overlap. Any stretch of two or more zeros that ends in a one produces exactly one detection, on the one. The machine stores three reachable states in two flip-flops, and the next-state inputs come from hand-derived D-type equations. The two state bits are brought out so that the progress of a match can be observed.

Top module: `trip_seq_det`

## Requirements
- R1: While `rst_n` is low, `state_q` is `2'b00` and `y_out` is 0, whatever the value of `x_in`. The reset takes effect at once, without waiting for a clock edge. When `rst_n` returns high, the machine starts from `2'b00`.
- R2: The state codes are: `2'b00` = no zero seen, `2'b01` = one trailing zero, `2'b10` = two or more trailing zeros. Code `2'b11` never appears after reset.
- R3: From `2'b00`, `x_in=0` moves to `2'b01` and `x_in=1` stays at `2'b00`. `y_out` is 0 in both cases.
- R4: From `2'b01`, `x_in=0` moves to `2'b10` and `x_in=1` returns to `2'b00`. `y_out` is 0 in both cases.
- R5: From `2'b10`, `x_in=0` stays at `2'b10` with `y_out=0`. `x_in=1` returns to `2'b00` with `y_out=1`.
- R6: `y_out` is 1 in a cycle exactly when the inputs sampled at the two previous edges since reset were 0, 0 and the present `x_in` is 1. Inputs sampled before the last reset never count.
- R7: Detection overlaps across zero runs. `0 0 0 1` detects once, on the one. `0 0 1 0 1` detects only on the first one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| x_in | input | 1 | Serial symbol, 0 = a, 1 = b |
| y_out | output | 1 | Detection flag, combinational from state and `x_in` |
| state_q | output | 2 | Present state bits, for observation |

## Verification
The hardest situation to reach from the ports is the spare code `2'b11`. No legal input sequence leads there, so the bench cannot drive the machine into it. Instead, the bench checks `state_q` after every edge, and an assertion watches for the code continuously.

The next most delicate case is a partial match that is cut off by reset. The bench applies two zeros, pulses reset with `x_in` held at 1, and then presents a one. It checks that no detection follows. Long zero runs and back-to-back near-misses exercise the self-loop on the two-zero state.

// File: rtl/trip_seq_det_pkg.sv
package trip_seq_det_pkg;
  localparam int STATE_W = 2;
  typedef logic [STATE_W-1:0] state_t;
  localparam state_t ST_NONE = 2'b00;  // no trailing zero
  localparam state_t ST_ONE  = 2'b01;  // one trailing zero
  localparam state_t ST_TWO  = 2'b10;  // two or more trailing zeros
endpackage

// File: rtl/trip_seq_det_next.sv
module trip_seq_det_next
  import trip_seq_det_pkg::*;
(
  input  state_t cur_s,
  input  logic   sym,
  output state_t nxt_s
);
  // Hand-derived D inputs; the spare code 11 follows the same equations.
  always_comb begin
    nxt_s[1] = (~sym & cur_s[0]) | (~sym & cur_s[1]);
    nxt_s[0] = ~cur_s[1] & ~cur_s[0] & ~sym;
  end
endmodule

// File: rtl/trip_seq_det_out.sv
module trip_seq_det_out (
  input  logic hi_bit,
  input  logic sym,
  output logic hit
);
  always_comb hit = hi_bit & sym;
endmodule

// File: rtl/trip_seq_det_sreg.sv
module trip_seq_det_sreg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/trip_seq_det.sv
module trip_seq_det
  import trip_seq_det_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               x_in,
  output logic               y_out,
  output logic [STATE_W-1:0] state_q
);
  state_t cur_s;
  state_t nxt_s;
  logic   step_en;

  assign step_en = 1'b1;  // advance one symbol every cycle

  trip_seq_det_next u_next (
    .cur_s (cur_s),
    .sym   (x_in),
    .nxt_s (nxt_s)
  );

  trip_seq_det_sreg #(.W(STATE_W)) u_sreg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step_en),
    .d     (nxt_s),
    .q     (cur_s)
  );

  trip_seq_det_out u_out (
    .hi_bit (cur_s[1]),
    .sym    (x_in),
    .hit    (y_out)
  );

  assign state_q = cur_s;
endmodule

// File: rtl/trip_seq_det_chk.sv
module trip_seq_det_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       x_in,
  input logic       y_out,
  input logic [1:0] state_q
);
  // R1: reset holds state and output low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (state_q == 2'b00 && !y_out));

  // R2: spare code never reached
  assert_no_spare_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'b11);

  // R3: first zero advances
  assert_first_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 2'b00 && !x_in) |=> state_q == 2'b01);

  // R4: one after a single zero abandons the match
  assert_break_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 2'b01 && x_in) |=> state_q == 2'b00);

  // R5: detection returns to the idle code
  assert_hit_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    y_out |=> state_q == 2'b00);

  // R6: a detection is always preceded by a zero
  assert_hit_after_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    y_out |-> ($past(x_in) == 1'b0 && x_in));
endmodule

bind trip_seq_det trip_seq_det_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .x_in    (x_in),
  .y_out   (y_out),
  .state_q (state_q)
);

// File: tb/trip_seq_det_tb.sv
module trip_seq_det_tb;
  logic       clk;
  logic       rst_n;
  logic       x_in;
  logic       y_out;
  logic [1:0] state_q;

  int n_chk;
  int n_bad;
  logic [1:0] hist;   // hist[0] = newest sampled symbol
  int         seen;   // symbols sampled since reset

  trip_seq_det u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_in    (x_in),
    .y_out   (y_out),
    .state_q (state_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model_state();
    if (seen == 0 || hist[0])             return 2'b00;
    if (seen >= 2 && hist[1:0] == 2'b00)  return 2'b10;
    return 2'b01;
  endfunction

  // Drive one symbol, check y in its cycle, then check the state after the edge.
  task automatic put(input logic b, input string req);
    logic exp_y;
    @(negedge clk);
    x_in = b;
    #2;
    exp_y = (seen >= 2) && (hist == 2'b00) && b;
    check({req, " R6 y"}, {1'b0, y_out}, {1'b0, exp_y});
    @(posedge clk);
    #1;
    hist = {hist[0], b};
    seen++;
    check({req, " state"}, state_q, model_state());
    n_chk++;
    if (state_q === 2'b11) begin
      n_bad++;
      $display("FAIL R2: actual 11 expected legal code");
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    x_in  = 1'b1;
    rst_n = 1'b0;
    #1;
    check("R1 reset state", state_q, 2'b00);
    check("R1 reset y", {1'b0, y_out}, 2'b00);
    @(posedge clk); #1;
    check("R1 held state", state_q, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    hist = 2'b11;
    seen = 0;
  endtask

  task automatic t_seq(input logic [15:0] bits, input int len, input string req);
    for (int i = len - 1; i >= 0; i--) put(bits[i], req);
  endtask

  task automatic t_arcs();
    // R3 self loop and advance, R4 both arcs, R5 both arcs
    t_seq(16'b1, 1, "R3 idle-one");
    t_seq(16'b0, 1, "R3 idle-zero");
    t_seq(16'b1, 1, "R4 one-break");
    t_seq(16'b00, 2, "R4 to-two");
    t_seq(16'b0, 1, "R5 dwell");
    t_seq(16'b1, 1, "R5 hit");
  endtask

  task automatic t_overlap();
    do_reset();
    t_seq(16'b0001, 4, "R7 0001");
    do_reset();
    t_seq(16'b00101, 5, "R7 00101");
    t_seq(16'b0000000011, 10, "R7 long run");
  endtask

  task automatic t_reset_cut();
    do_reset();
    t_seq(16'b00, 2, "R1 prefix");
    do_reset();
    t_seq(16'b1, 1, "R1 after cut");
  endtask

  task automatic t_random();
    logic b;
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      b = ($urandom % 3) == 0;
      put(b, "R6 random");
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    hist = 2'b11; seen = 0;
    x_in = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 time-zero state", state_q, 2'b00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_arcs();
    t_overlap();
    t_reset_cut();
    t_random();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule